// File: doc/BRIEF.md
# Sleep-Request Power State Controller

This block converts two active-low sleep requests into moves of a three-state power mode machine. The states are full-on (ACTIVE), a partial state where only the microcontroller rail group stays powered (MCU ONLY), and a deep state where both rail groups are off (DEEP). One request governs the SoC rail group and the other governs the MCU rail group. The two requests are ranked: the MCU request takes precedence over the SoC request.

Each request level is formed as the OR of a software bit and an external pin. The pin contributes only when its select bit is set. Pins go through a synchronizer. The block then detects falling and rising edges on each combined level. A falling edge asks for a lower state and a rising edge cancels that request. A per-request mask removes a request from consideration entirely. The block decodes the edges into a target state. It drives registered enables for the two rail groups and reports the current state.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: A combined request level equals (select AND synchronized pin) OR software bit. With its select bit at 0, a pin has no effect on the state.
- R2: A change on a selected pin moves the state on the third rising clock edge after it is applied. A change on a software bit moves the state on the first edge.
- R3: Synchronous reset puts the machine in ACTIVE with both enables high. Request levels already low at reset are not seen as falling edges.
- R4: In ACTIVE, an unmasked falling SoC request moves the machine to MCU ONLY when the MCU request is high or masked.
- R5: In ACTIVE or MCU ONLY, an unmasked falling MCU request moves the machine to DEEP, whatever the SoC request does.
- R6: In DEEP, an unmasked rising MCU request moves the machine to ACTIVE when the SoC level is 1 or the SoC request is masked. It moves the machine to MCU ONLY when the SoC level is 0.
- R7: In MCU ONLY, an unmasked rising SoC request moves the machine to ACTIVE when the MCU level is 1. The edge is ignored when the unmasked MCU level is 0.
- R8: With the MCU request masked, its edges have no effect. A rising SoC request in DEEP or MCU ONLY then moves the machine to ACTIVE.
- R9: With the SoC request masked, its edges have no effect on the state.
- R10: pwr_state encodes ACTIVE=0, MCU ONLY=1 and DEEP=2. soc_rail_en is 1 only in ACTIVE. mcu_rail_en is 1 in ACTIVE and MCU ONLY. All three outputs are registered.
- R11: When conditions for several targets hold in one cycle, the lowest power target wins: DEEP, then MCU ONLY, then ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_req_soc | input | 1 | Asynchronous SoC sleep request pin, active low |
| pin_req_mcu | input | 1 | Asynchronous MCU sleep request pin, active low |
| pin_sel_soc | input | 1 | Enables the SoC request pin |
| pin_sel_mcu | input | 1 | Enables the MCU request pin |
| sw_req_soc | input | 1 | Software SoC request bit |
| sw_req_mcu | input | 1 | Software MCU request bit |
| mask_soc | input | 1 | Ignore the SoC request when 1 |
| mask_mcu | input | 1 | Ignore the MCU request when 1 |
| pwr_state | output | 2 | Current state: 0 ACTIVE, 1 MCU ONLY, 2 DEEP |
| soc_rail_en | output | 1 | SoC rail group enable |
| mcu_rail_en | output | 1 | MCU rail group enable |

## Verification
The hardest case to reach is MCU ONLY with the MCU request low and unmasked, where a SoC wake must be refused. An unmasked fall of the MCU request would leave that state at once. The stimulus therefore masks the MCU request, lowers it, removes the mask without creating an edge, and then raises the SoC request. A behavioural model built from the transition rules tracks the outputs on every cycle, including the three-edge pin latency.

// File: rtl/sleep_pwr_pkg.sv
package sleep_pwr_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_MCU    = 2'd1,
    PS_DEEP   = 2'd2
  } pwr_state_t;

  localparam int REQ_SOC = 0;
  localparam int REQ_MCU = 1;
  localparam int NREQ    = 2;
endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[i] <= d;
        end else if (i == 0) begin
          chain[i] <= d;
        end else begin
          chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spc_edge.sv
module spc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    lvl_d <= lvl;
  end

  assign rise = !rst && lvl && !lvl_d;
  assign fall = !rst && !lvl && lvl_d;
endmodule

// File: rtl/spc_decode.sv
module spc_decode
  import sleep_pwr_pkg::*;
(
  input  pwr_state_t           cur,
  input  logic [NREQ-1:0]      lvl,
  input  logic [NREQ-1:0]      rise,
  input  logic [NREQ-1:0]      fall,
  input  logic [NREQ-1:0]      msk,
  output pwr_state_t           nxt
);
  logic in_act, in_deep;
  logic soc_fall, soc_rise, mcu_fall, mcu_rise;
  logic mcu_ok, soc_up;
  logic go_deep, go_mcu, go_act;

  always_comb begin
    in_act   = (cur == PS_ACTIVE);
    in_deep  = (cur == PS_DEEP);
    soc_fall = fall[REQ_SOC] && !msk[REQ_SOC];
    soc_rise = rise[REQ_SOC] && !msk[REQ_SOC];
    mcu_fall = fall[REQ_MCU] && !msk[REQ_MCU];
    mcu_rise = rise[REQ_MCU] && !msk[REQ_MCU];
    mcu_ok   = msk[REQ_MCU] || lvl[REQ_MCU];
    soc_up   = msk[REQ_SOC] || lvl[REQ_SOC];

    go_deep = !in_deep && mcu_fall;
    go_mcu  = (in_act && soc_fall && mcu_ok) ||
              (in_deep && mcu_rise && !soc_up);
    go_act  = (in_deep && mcu_rise && soc_up) ||
              (!in_act && soc_rise && mcu_ok);

    if (go_deep)     nxt = PS_DEEP;
    else if (go_mcu) nxt = PS_MCU;
    else if (go_act) nxt = PS_ACTIVE;
    else             nxt = cur;
  end
endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import sleep_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_req_soc,
  input  logic       pin_req_mcu,
  input  logic       pin_sel_soc,
  input  logic       pin_sel_mcu,
  input  logic       sw_req_soc,
  input  logic       sw_req_mcu,
  input  logic       mask_soc,
  input  logic       mask_mcu,
  output logic [1:0] pwr_state,
  output logic       soc_rail_en,
  output logic       mcu_rail_en
);
  logic [NREQ-1:0] pin_v, sel_v, sw_v, msk_v;
  logic [NREQ-1:0] pin_s, lvl, rise, fall;
  pwr_state_t      state_q, state_n;

  assign pin_v = {pin_req_mcu, pin_req_soc};
  assign sel_v = {pin_sel_mcu, pin_sel_soc};
  assign sw_v  = {sw_req_mcu,  sw_req_soc};
  assign msk_v = {mask_mcu,    mask_soc};

  generate
    for (genvar r = 0; r < NREQ; r++) begin : g_req
      spc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_v[r]),
        .q   (pin_s[r])
      );

      assign lvl[r] = (sel_v[r] && pin_s[r]) || sw_v[r];

      spc_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl[r]),
        .rise (rise[r]),
        .fall (fall[r])
      );
    end
  endgenerate

  spc_decode u_dec (
    .cur  (state_q),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall),
    .msk  (msk_v),
    .nxt  (state_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PS_ACTIVE;
      soc_rail_en <= 1'b1;
      mcu_rail_en <= 1'b1;
    end else begin
      state_q     <= state_n;
      soc_rail_en <= (state_n == PS_ACTIVE);
      mcu_rail_en <= (state_n != PS_DEEP);
    end
  end

  assign pwr_state = state_q;
endmodule

// File: rtl/sleep_pwr_ctrl_chk.sv
module sleep_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mask_soc,
  input logic       mask_mcu,
  input logic [1:0] pwr_state,
  input logic       soc_rail_en,
  input logic       mcu_rail_en
);
  assert_reset_active_R3: assert property (@(posedge clk)
    rst |=> (pwr_state == 2'd0 && soc_rail_en && mcu_rail_en));

  assert_rail_order_R10: assert property (@(posedge clk) disable iff (rst)
    soc_rail_en |-> (mcu_rail_en && pwr_state == 2'd0));

  assert_legal_code_R10: assert property (@(posedge clk) disable iff (rst)
    pwr_state != 2'd3);

  assert_mcu_mask_no_deep_R8: assert property (@(posedge clk) disable iff (rst)
    (mask_mcu && pwr_state != 2'd2) |=> pwr_state != 2'd2);

  assert_both_masked_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mask_soc && mask_mcu) |=> $stable(pwr_state));
endmodule

bind sleep_pwr_ctrl sleep_pwr_ctrl_chk chk_i (.*);

// File: tb/sleep_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_pwr_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_req_soc = 1'b1, pin_req_mcu = 1'b1;
  logic pin_sel_soc = 1'b0, pin_sel_mcu = 1'b0;
  logic sw_req_soc = 1'b0, sw_req_mcu = 1'b1;
  logic mask_soc = 1'b0, mask_mcu = 1'b0;
  logic [1:0] pwr_state;
  logic soc_rail_en, mcu_rail_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sleep_pwr_ctrl dut_i (
    .clk(clk), .rst(rst),
    .pin_req_soc(pin_req_soc), .pin_req_mcu(pin_req_mcu),
    .pin_sel_soc(pin_sel_soc), .pin_sel_mcu(pin_sel_mcu),
    .sw_req_soc(sw_req_soc), .sw_req_mcu(sw_req_mcu),
    .mask_soc(mask_soc), .mask_mcu(mask_mcu),
    .pwr_state(pwr_state), .soc_rail_en(soc_rail_en), .mcu_rail_en(mcu_rail_en)
  );

  // Behavioural reference: pin history queues, previous levels, state as integer.
  bit pq_soc[$], pq_mcu[$];
  int m_state = 0;
  bit m_prev_soc, m_prev_mcu;

  always @(posedge clk) begin
    bit ls, lm, fs, rs, fm, rm, mok, sup;
    int tgt;
    if (pq_soc.size() < 2) begin
      pq_soc = '{pin_req_soc, pin_req_soc};
      pq_mcu = '{pin_req_mcu, pin_req_mcu};
    end
    ls = (pin_sel_soc && pq_soc[1]) || sw_req_soc;
    lm = (pin_sel_mcu && pq_mcu[1]) || sw_req_mcu;
    if (rst) begin
      m_state = 0;
      pq_soc = '{pin_req_soc, pin_req_soc};
      pq_mcu = '{pin_req_mcu, pin_req_mcu};
    end else begin
      fs = !mask_soc && m_prev_soc && !ls;
      rs = !mask_soc && !m_prev_soc && ls;
      fm = !mask_mcu && m_prev_mcu && !lm;
      rm = !mask_mcu && !m_prev_mcu && lm;
      mok = mask_mcu || lm;
      sup = mask_soc || ls;
      tgt = m_state;
      if (m_state != 2 && fm) tgt = 2;
      else if (m_state == 0 && fs && mok) tgt = 1;
      else if (m_state == 2 && rm) tgt = sup ? 0 : 1;
      else if (m_state != 0 && rs && mok) tgt = 0;
      m_state = tgt;
      pq_soc = '{pin_req_soc, pq_soc[0]};
      pq_mcu = '{pin_req_mcu, pq_mcu[0]};
    end
    m_prev_soc = ls;
    m_prev_mcu = lm;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pwr_state !== m_state[1:0] || soc_rail_en !== (m_state == 0) ||
          mcu_rail_en !== (m_state != 2)) begin
        errors++;
        $display("FAIL R10 model compare: state=%0d soc=%0b mcu=%0b expected state=%0d",
                 pwr_state, soc_rail_en, mcu_rail_en, m_state);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] exp);
    checks++;
    if (pwr_state !== exp || soc_rail_en !== (exp == 2'd0) || mcu_rail_en !== (exp != 2'd2)) begin
      errors++;
      $display("FAIL %s: state=%0d soc=%0b mcu=%0b expected state=%0d",
               tag, pwr_state, soc_rail_en, mcu_rail_en, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(2);
    chk("R3 reset with low SoC level", 2'd0);
    sw_req_soc = 1'b1; step(1);
    chk("R3 rise in ACTIVE", 2'd0);
    sw_req_soc = 1'b0; step(1);
    chk("R4 SoC fall to MCU ONLY", 2'd1);
    sw_req_mcu = 1'b0; step(1);
    chk("R5 MCU fall to DEEP", 2'd2);
    sw_req_soc = 1'b1; step(1);
    chk("R7 SoC wake refused in DEEP", 2'd2);
    sw_req_mcu = 1'b1; step(1);
    chk("R6 MCU rise with SoC high", 2'd0);
    sw_req_soc = 1'b0; sw_req_mcu = 1'b0; step(1);
    chk("R11 both fall to DEEP", 2'd2);
    sw_req_mcu = 1'b1; step(1);
    chk("R6 MCU rise with SoC low", 2'd1);
    sw_req_soc = 1'b1; step(1);
    chk("R7 SoC rise to ACTIVE", 2'd0);
    sw_req_soc = 1'b0; step(1);
    chk("R4 second fall", 2'd1);
    mask_mcu = 1'b1; sw_req_mcu = 1'b0; step(1);
    chk("R8 masked MCU fall ignored", 2'd1);
    mask_mcu = 1'b0; step(1);
    chk("R8 unmask without edge", 2'd1);
    sw_req_soc = 1'b1; step(1);
    chk("R7 SoC wake refused, MCU low", 2'd1);
    mask_mcu = 1'b1; sw_req_soc = 1'b0; step(1);
    chk("R8 SoC fall in MCU ONLY", 2'd1);
    sw_req_soc = 1'b1; step(1);
    chk("R8 SoC rise with MCU masked", 2'd0);
    mask_mcu = 1'b0; sw_req_mcu = 1'b1; step(1);
    chk("R8 MCU rise in ACTIVE", 2'd0);
    mask_soc = 1'b1; sw_req_soc = 1'b0; step(1);
    chk("R9 masked SoC fall ignored", 2'd0);
    mask_soc = 1'b0; step(1);
    chk("R9 unmask without edge", 2'd0);
    sw_req_mcu = 1'b0; step(1);
    chk("R5 fall from ACTIVE", 2'd2);
    mask_soc = 1'b1; sw_req_mcu = 1'b1; step(1);
    chk("R6 MCU rise with SoC masked", 2'd0);
    mask_soc = 1'b0; sw_req_soc = 1'b1; step(1);
    chk("R6 settle", 2'd0);
    pin_sel_soc = 1'b1; sw_req_soc = 1'b0; step(3);
    chk("R1 pin holds level", 2'd0);
    pin_req_soc = 1'b0; step(2);
    chk("R2 pin not yet through", 2'd0);
    step(1);
    chk("R2 pin fall on third edge", 2'd1);
    sw_req_soc = 1'b1; step(1);
    chk("R1 software bit raises level", 2'd0);
    pin_req_soc = 1'b1; step(2);
    pin_req_soc = 1'b0; step(4);
    chk("R1 OR keeps level high", 2'd0);
    pin_req_mcu = 1'b0; step(4);
    chk("R1 deselected pin ignored", 2'd0);
    pin_req_mcu = 1'b1; step(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule